// File: doc/BRIEF.md
# Split Dual 8-bit Reload Timer

This block holds two free-standing 8-bit up-counters, a low half and a high half, behind one small register port. Each half counts on single-cycle tick enables in the system clock domain and, on wrapping past 0xFF, reloads from its own reload register and sets a sticky overflow flag. Each half has a tick-rate bit: set, the half counts on every system clock. Clear, it counts at the rate picked by one select bit that both halves share: the system clock divided by 12, or rising edges of an asynchronous external clock divided by 8. The external clock is synchronized with two flops and edge-detected before its prescaler. Both prescalers run all the time and are shared by the halves.

Run control is deliberately asymmetric: one run bit gates only the high half, and the low half always counts. The single interrupt output is a level. It follows the high flag whenever the interrupt enable is set, and it follows the low flag only when a separate low-flag enable is also set. Software clears flags by writing 0. A counter write in the same cycle as a tick wins, and an overflow in the same cycle as a flag-clear write leaves the flag set.

Register map (3-bit address, 8-bit data, reads return data one cycle after the address is presented): 0 = control, 1 = low count, 2 = high count, 3 = low reload, 4 = high reload, other addresses read 0. Control bits: 0 high run, 1 shared external select, 2 high fast, 3 low fast, 4 low-flag interrupt enable, 5 interrupt enable, 6 low flag, 7 high flag.

Top module: `split_reload_timer`

## Requirements
- R1: After reset every register at addresses 0 to 4 reads 0 and irq is low; the control register fields sit at bits 0 high run, 1 external select, 2 high fast, 3 low fast, 4 low-flag enable, 5 interrupt enable, 6 low flag, 7 high flag.
- R2: A half that ticks while its count is 0xFF loads its reload register (address 3 low, 4 high) instead of 0x00.
- R3: With control bit 0 clear the high count holds; the low count advances whatever bit 0 holds.
- R4: With its fast bit set (bit 2 high, bit 3 low) a half advances by one on every clock, so 50 clocks add 50.
- R5: With its fast bit clear a half follows shared bit 1: 0 gives one tick per 12 clocks, 1 gives one tick per 8 synchronized rising edges of ext_clk, for both halves alike.
- R6: A wrap sets the half's flag (bit 7 high, bit 6 low); hardware never clears it; a control write loads the written flag bits, except that an overflow in the same cycle leaves the flag set.
- R7: irq is high while bit 5 and the high flag are both set, and low while bit 5 is clear.
- R8: The low flag drives irq only while bit 4 is set as well.
- R9: A write to a count register takes effect in place of a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk | input | 1 | Asynchronous external count clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data, one cycle after rd_addr |
| irq | output | 1 | Level interrupt request |

## Verification
A counter that steps on the wrong tick shows up as a wrong count difference over a window that is a whole multiple of the prescaler period, visible at the next read, one cycle later. A wrong reload or missed flag shows within one or two cycles of the wrap, as a read of the count or control register and as the irq level. Corrupted flag or enable state appears on irq in the same cycle, because irq is a combinational function of the stored bits.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd4;

  localparam int B_RUN_HI  = 0;
  localparam int B_EXT_SEL = 1;
  localparam int B_FAST_HI = 2;
  localparam int B_FAST_LO = 3;
  localparam int B_LO_IEN  = 4;
  localparam int B_IRQ_EN  = 5;
  localparam int B_FLAG_LO = 6;
  localparam int CFG_W     = 6;

  // Tick choice for one half.
  function automatic logic srt_pick(input logic fast, input logic ext_sel,
                                    input logic t_div, input logic t_ext);
    return fast ? 1'b1 : (ext_sel ? t_ext : t_div);
  endfunction

  // Next count on a tick: wrap loads the reload value.
  function automatic logic [REG_W-1:0] srt_advance(input logic [REG_W-1:0] cnt,
                                                   input logic [REG_W-1:0] rld);
    return (&cnt) ? rld : cnt + 1'b1;
  endfunction
endpackage

// File: rtl/srt_prescale.sv
module srt_prescale #(
  parameter int DIV_SYS = 12,
  parameter int DIV_EXT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic tick_div,
  output logic tick_ext
);
  localparam int SW = (DIV_SYS > 1) ? $clog2(DIV_SYS) : 1;
  localparam int EW = (DIV_EXT > 1) ? $clog2(DIV_EXT) : 1;

  logic [SW-1:0] sys_cnt;
  logic [EW-1:0] ext_cnt;
  logic [2:0]    ext_sh;
  logic          ext_rise;

  assign tick_div = (sys_cnt == SW'(DIV_SYS - 1));
  assign ext_rise = ext_sh[1] & ~ext_sh[2];
  assign tick_ext = ext_rise && (ext_cnt == EW'(DIV_EXT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_cnt <= '0;
      ext_cnt <= '0;
      ext_sh  <= '0;
    end else begin
      ext_sh  <= {ext_sh[1:0], ext_clk};
      sys_cnt <= tick_div ? '0 : sys_cnt + 1'b1;
      if (ext_rise) ext_cnt <= tick_ext ? '0 : ext_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/srt_half.sv
module srt_half
  import srt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fast,
  input  logic             ext_sel,
  input  logic             tick_div,
  input  logic             tick_ext,
  input  logic             cnt_we,
  input  logic             rld_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] cnt,
  output logic [REG_W-1:0] rld,
  output logic             tick,
  output logic             ovf
);
  assign tick = run && srt_pick(fast, ext_sel, tick_div, tick_ext);
  assign ovf  = tick && !cnt_we && (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      rld <= '0;
    end else begin
      if (cnt_we)    cnt <= wdata;
      else if (tick) cnt <= srt_advance(cnt, rld);
      if (rld_we)    rld <= wdata;
    end
  end
endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
  import srt_pkg::*;
#(
  parameter int DIV_SYS = 12,
  parameter int DIV_EXT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq
);
  logic [CFG_W-1:0] cfg;
  logic [1:0]       flag_v, tick_v, ovf_v, cnt_we_v, rld_we_v, run_v, fast_v;
  logic [REG_W-1:0] cnt_v [2];
  logic [REG_W-1:0] rld_v [2];
  logic             tick_div, tick_ext, ctrl_we;

  // Named internal events for the checker.
  logic             ovf_lo, ovf_hi, flag_lo, flag_hi, run_hi, irq_en, lo_ien, cnt_hi_we;
  logic [REG_W-1:0] cnt_lo, cnt_hi, rld_lo, rld_hi;

  srt_prescale #(.DIV_SYS(DIV_SYS), .DIV_EXT(DIV_EXT)) u_pre (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
    .tick_div(tick_div), .tick_ext(tick_ext)
  );

  assign ctrl_we = wr_en && (wr_addr == A_CTRL);
  assign run_v   = {cfg[B_RUN_HI], 1'b1};
  assign fast_v  = {cfg[B_FAST_HI], cfg[B_FAST_LO]};

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign cnt_we_v[h] = wr_en && (wr_addr == A_CNT_LO + ADDR_W'(h));
    assign rld_we_v[h] = wr_en && (wr_addr == A_RLD_LO + ADDR_W'(h));

    srt_half u_half (
      .clk(clk), .rst_n(rst_n), .run(run_v[h]), .fast(fast_v[h]),
      .ext_sel(cfg[B_EXT_SEL]), .tick_div(tick_div), .tick_ext(tick_ext),
      .cnt_we(cnt_we_v[h]), .rld_we(rld_we_v[h]), .wdata(wr_data),
      .cnt(cnt_v[h]), .rld(rld_v[h]), .tick(tick_v[h]), .ovf(ovf_v[h])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) flag_v[h] <= 1'b0;
      else        flag_v[h] <= ovf_v[h] | (ctrl_we ? wr_data[B_FLAG_LO + h] : flag_v[h]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cfg <= '0;
    else if (ctrl_we) cfg <= wr_data[CFG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else begin
      case (rd_addr)
        A_CTRL:   rd_data <= {flag_v, cfg};
        A_CNT_LO: rd_data <= cnt_v[0];
        A_CNT_HI: rd_data <= cnt_v[1];
        A_RLD_LO: rd_data <= rld_v[0];
        A_RLD_HI: rd_data <= rld_v[1];
        default:  rd_data <= '0;
      endcase
    end
  end

  assign irq_en    = cfg[B_IRQ_EN];
  assign lo_ien    = cfg[B_LO_IEN];
  assign run_hi    = cfg[B_RUN_HI];
  assign flag_lo   = flag_v[0];
  assign flag_hi   = flag_v[1];
  assign ovf_lo    = ovf_v[0];
  assign ovf_hi    = ovf_v[1];
  assign cnt_lo    = cnt_v[0];
  assign cnt_hi    = cnt_v[1];
  assign rld_lo    = rld_v[0];
  assign rld_hi    = rld_v[1];
  assign cnt_hi_we = cnt_we_v[1];

  assign irq = irq_en & (flag_hi | (flag_lo & lo_ien));
endmodule

// File: rtl/srt_checker.sv
module srt_checker
  import srt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             irq_en,
  input logic             lo_ien,
  input logic             run_hi,
  input logic             ctrl_we,
  input logic             cnt_hi_we,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] cnt_lo,
  input logic [REG_W-1:0] cnt_hi,
  input logic [REG_W-1:0] rld_lo,
  input logic [REG_W-1:0] rld_hi,
  input logic             ovf_lo,
  input logic             ovf_hi,
  input logic             flag_lo,
  input logic             flag_hi
);
  // R2
  reload_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hi |=> cnt_hi == $past(rld_hi));
  // R2
  reload_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_lo |=> cnt_lo == $past(rld_lo));
  // R3
  hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_hi && !cnt_hi_we) |=> $stable(cnt_hi));
  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hi || ovf_lo) |=> (flag_hi || !$past(ovf_hi)) && (flag_lo || !$past(ovf_lo)));
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_hi && !ctrl_we) |=> flag_hi);
  // R7
  irq_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_hi && irq_en) |-> irq);
  // R7
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  // R8
  lo_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_hi && !lo_ien) |-> !irq);
  // R9
  wr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hi_we |=> cnt_hi == $past(wr_data));
endmodule

bind split_reload_timer srt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .irq_en(irq_en), .lo_ien(lo_ien),
  .run_hi(run_hi), .ctrl_we(ctrl_we), .cnt_hi_we(cnt_hi_we), .wr_data(wr_data),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .rld_lo(rld_lo), .rld_hi(rld_hi),
  .ovf_lo(ovf_lo), .ovf_hi(ovf_hi), .flag_lo(flag_lo), .flag_hi(flag_hi)
);

// File: tb/test_split_reload_timer.sv
`timescale 1ns/100ps
module test_split_reload_timer;
  logic       clk = 1'b0;
  logic       rst_n, ext_clk, wr_en, irq;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  split_reload_timer i_split_reload_timer (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  always #2 clk = ~clk;

  typedef struct {
    bit       is_irq;
    bit [7:0] exp;
    int       due;
    string    req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    vectors = 0;
  int    miscmp = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expectations when due and compares at the ports.
  initial forever begin
    @(negedge clk);
    #0.5;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [7:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {7'b0, irq} : rd_data;
      vectors++;
      if (act !== it.exp) begin
        miscmp++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [7:0] e, input string r);
    rd_addr = a;
    q.push_back('{1'b0, e, cyc + 1, r});
    @(negedge clk);
    #1;
  endtask

  task automatic chk_irq(input logic e, input string r);
    @(negedge clk);
    q.push_back('{1'b1, {7'b0, e}, cyc, r});
    #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] a, b;
    rst_n = 1'b0; ext_clk = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_rd(3'd0, 8'h00, "R1 ctrl");
    chk_rd(3'd2, 8'h00, "R1 cnt_hi");
    chk_rd(3'd4, 8'h00, "R1 rld_hi");
    chk_irq(1'b0, "R1 irq");

    // R5 divide-by-12 on the high half
    wr(3'd0, 8'h01);
    peek(3'd2, a);
    repeat (119) @(negedge clk);
    chk_rd(3'd2, a + 8'd10, "R5 div12");

    // R4 fast high half
    wr(3'd0, 8'h05);
    peek(3'd2, a);
    repeat (49) @(negedge clk);
    chk_rd(3'd2, a + 8'd50, "R4 fast hi");

    // R3 run clear holds the high half
    wr(3'd0, 8'h04);
    peek(3'd2, a);
    repeat (39) @(negedge clk);
    chk_rd(3'd2, a, "R3 hi held");

    // R3 / R4 low half runs without run bit
    wr(3'd0, 8'h08);
    peek(3'd1, a);
    repeat (49) @(negedge clk);
    chk_rd(3'd1, a + 8'd50, "R3 R4 lo runs");

    // R5 shared external select, both halves
    wr(3'd0, 8'h03);
    peek(3'd2, a);
    peek(3'd1, b);
    for (int i = 0; i < 64; i++) begin
      ext_clk = 1'b1; repeat (4) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    chk_rd(3'd2, a + 8'd8, "R5 ext hi");
    chk_rd(3'd1, b + 8'd8, "R5 ext lo");

    // R9 / R2 / R6 high half wrap with reload
    wr(3'd0, 8'h04);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h30);
    wr(3'd0, 8'h05);
    wr(3'd2, 8'hFE);
    chk_rd(3'd2, 8'hFE, "R9 write wins");
    chk_rd(3'd2, 8'hFF, "R2 hi step");
    chk_rd(3'd2, 8'h30, "R2 hi reload");
    chk_rd(3'd0, 8'h85, "R6 hi flag set");
    chk_irq(1'b0, "R7 irq_en off");
    wr(3'd0, 8'hA4);
    chk_irq(1'b1, "R7 hi flag irq");
    repeat (5) @(negedge clk);
    chk_rd(3'd0, 8'hA4, "R6 sticky");
    wr(3'd0, 8'h24);
    chk_irq(1'b0, "R6 R7 flag cleared");
    chk_rd(3'd0, 8'h24, "R6 cleared read");

    // R2 / R8 low half wrap and low-flag enable
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h28);
    wr(3'd1, 8'hFE);
    chk_rd(3'd1, 8'hFE, "R9 lo write");
    chk_rd(3'd1, 8'hFF, "R2 lo step");
    chk_rd(3'd1, 8'h80, "R2 lo reload");
    chk_rd(3'd0, 8'h68, "R6 lo flag set");
    chk_irq(1'b0, "R8 lo masked");
    wr(3'd0, 8'h78);
    chk_irq(1'b1, "R8 lo enabled");

    // R6 clear write colliding with overflow
    wr(3'd0, 8'h04);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h10);
    wr(3'd0, 8'h05);
    wr(3'd2, 8'hFE);
    @(negedge clk);
    wr(3'd0, 8'h05);
    chk_rd(3'd0, 8'h85, "R6 overflow beats clear");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule